// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Controller

This block combines the event pulses of a counter/timer into one interrupt request line. There are four sources. One is the counter's terminal-count event, which covers wrap-around in up mode and turnaround at zero in up/down mode. The other three are the compare-or-capture events of channels 0, 1 and 2. Each source sets its own sticky pending flag. Each flag has its own enable (mask) bit, and a single global timer enable also gates the request.

The request output is a one-cycle pulse. It fires when the combined condition "global enable and at least one flag whose mask bit is set" goes from false to true. While that condition stays true, further events do not produce another pulse. Software must first clear what is pending. If a mask bit or the global enable is turned on while a matching flag is already waiting, the condition becomes true and a fresh pulse fires.

Software clears flags in one of two ways. A write-one-to-clear strobe clears the flags whose data bits are 1. A write-zero strobe clears the flags whose data bits are 0. Masks and the global enable are loaded through plain write strobes.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: Flag, mask, event and clear vectors use bit 0 for the terminal-count source and bits 1, 2 and 3 for the channel 0, 1 and 2 compare/capture sources.
- R2: An event pulse on a bit sets that flag on the next clock edge, whatever the mask and global enable are. The flag then stays set until software clears it.
- R3: `irq_o` is never asserted unless, one cycle earlier, the global enable was 1 and some flag was set together with its mask bit.
- R4: `irq_o` is high for exactly one cycle. It goes high one clock after the masked-pending condition rises, so an event sampled at edge t gives a pulse after edge t+1.
- R5: While the masked-pending condition is already true, a further masked event raises no new pulse. Once all masked flags are cleared, the next masked event pulses again.
- R6: If a mask bit or the global enable is written to 1 while a matching flag is set and nothing else was masked-pending, a pulse follows.
- R7: With `clr1_en_i` high, flags whose `clr1_bits_i` bit is 1 clear. With `wr0_en_i` high, flags whose `wr0_bits_i` bit is 0 clear. All other flags are unchanged.
- R8: An event on a flag in the same cycle as a software clear of that flag leaves the flag set.
- R9: Synchronous reset clears all flags, masks, the global enable and `irq_o`.
- R10: `mask_we_i` loads `mask_d_i` into the masks, and `gie_we_i` loads `gie_d_i` into the global enable, both on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_SRC | Event pulses, one per source |
| clr1_en_i | input | 1 | Write-one-to-clear strobe |
| clr1_bits_i | input | N_SRC | Flags to clear where 1 |
| wr0_en_i | input | 1 | Write-zero clear strobe |
| wr0_bits_i | input | N_SRC | Flags to clear where 0 |
| mask_we_i | input | 1 | Mask write strobe |
| mask_d_i | input | N_SRC | New mask value |
| gie_we_i | input | 1 | Global enable write strobe |
| gie_d_i | input | 1 | New global enable value |
| flag_o | output | N_SRC | Pending flags |
| mask_o | output | N_SRC | Mask bits |
| gie_o | output | 1 | Global enable |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The bench sends a second masked event while one is already pending. A design that edge-detects each flag on its own would pulse again here. The bench also enables a mask, or the global enable, over a flag that is already waiting. A design that only watches event arrival would stay silent in that case. Same-cycle event and clear collisions expose a design that lets the clear win, because the flag would drop. Mixed strobes with both clear styles catch an inverted write-zero polarity.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  // Source count: terminal count plus three channels
  localparam int NUM_SRC = 4;
endpackage

// File: rtl/tmr_irq_flag_bank.sv
module tmr_irq_flag_bank #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr1_en_i,
  input  logic [N_SRC-1:0] clr1_bits_i,
  input  logic             wr0_en_i,
  input  logic [N_SRC-1:0] wr0_bits_i,
  output logic [N_SRC-1:0] flag_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    logic kill;
    logic q;
    assign kill = (clr1_en_i & clr1_bits_i[g]) | (wr0_en_i & ~wr0_bits_i[g]);
    always_ff @(posedge clk) begin
      if (rst)            q <= 1'b0;
      else if (evt_i[g])  q <= 1'b1;   // set wins over clear
      else if (kill)      q <= 1'b0;
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/tmr_irq_mask_reg.sv
module tmr_irq_mask_reg #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_d_i,
  input  logic             gie_we_i,
  input  logic             gie_d_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             gie_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      gie_o  <= 1'b0;
    end else begin
      if (mask_we_i) mask_o <= mask_d_i;
      if (gie_we_i)  gie_o  <= gie_d_i;
    end
  end
endmodule

// File: rtl/tmr_irq_req_gen.sv
module tmr_irq_req_gen #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             gie_i,
  output logic             irq_o
);
  logic pend;
  logic pend_q;

  assign pend = gie_i & (|(flag_i & mask_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= pend;
      irq_o  <= pend & ~pend_q;
    end
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int N_SRC = tmr_irq_pkg::NUM_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr1_en_i,
  input  logic [N_SRC-1:0] clr1_bits_i,
  input  logic             wr0_en_i,
  input  logic [N_SRC-1:0] wr0_bits_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_d_i,
  input  logic             gie_we_i,
  input  logic             gie_d_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             gie_o,
  output logic             irq_o
);
  tmr_irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .clr1_en_i(clr1_en_i), .clr1_bits_i(clr1_bits_i),
    .wr0_en_i(wr0_en_i), .wr0_bits_i(wr0_bits_i),
    .flag_o(flag_o)
  );

  tmr_irq_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk(clk), .rst(rst),
    .mask_we_i(mask_we_i), .mask_d_i(mask_d_i),
    .gie_we_i(gie_we_i), .gie_d_i(gie_d_i),
    .mask_o(mask_o), .gie_o(gie_o)
  );

  tmr_irq_req_gen #(.N_SRC(N_SRC)) u_req (
    .clk(clk), .rst(rst),
    .flag_i(flag_o), .mask_i(mask_o), .gie_i(gie_o),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk #(
  parameter int N_SRC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] evt_i,
  input logic             clr1_en_i,
  input logic [N_SRC-1:0] clr1_bits_i,
  input logic             wr0_en_i,
  input logic [N_SRC-1:0] wr0_bits_i,
  input logic             mask_we_i,
  input logic [N_SRC-1:0] mask_d_i,
  input logic             gie_we_i,
  input logic             gie_d_i,
  input logic [N_SRC-1:0] flag_o,
  input logic [N_SRC-1:0] mask_o,
  input logic             gie_o,
  input logic             irq_o
);
  logic mpend;
  logic [N_SRC-1:0] kill_bits;
  assign mpend     = gie_o && (|(flag_o & mask_o));
  assign kill_bits = ({N_SRC{clr1_en_i}} & clr1_bits_i) | ({N_SRC{wr0_en_i}} & ~wr0_bits_i);

  // R2: event sets its flag on the next edge
  a_r2_evt_sets: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

  // R2: with no event and no clear, flags hold
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (!(|evt_i) && !clr1_en_i && !wr0_en_i) |=> $stable(flag_o));

  // R3: a request needs masked-pending state one cycle earlier
  a_r3_needs_pend: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(mpend));

  // R4: the request is a single-cycle pulse
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R5: no pulse when the condition was already true two cycles back
  a_r5_no_repeat: assert property (@(posedge clk) disable iff (rst)
    ($past(mpend) && $past(mpend, 2)) |-> !irq_o);

  // R7: cleared bits without an event are zero next cycle
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (|(kill_bits & ~evt_i)) |=> ((flag_o & $past(kill_bits & ~evt_i)) == '0));

  // R8: a set in the same cycle as a clear wins
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|(kill_bits & evt_i)) |=> ((flag_o & $past(kill_bits & evt_i)) == $past(kill_bits & evt_i)));

  // R9: first cycle after reset shows cleared state
  a_r9_reset: assert property (@(posedge clk)
    $past(rst) |-> (flag_o == '0 && mask_o == '0 && !gie_o && !irq_o));

  // R10: mask and global enable writes land on the next edge
  a_r10_mask_wr: assert property (@(posedge clk) disable iff (rst)
    mask_we_i |=> (mask_o == $past(mask_d_i)));
  a_r10_gie_wr: assert property (@(posedge clk) disable iff (rst)
    gie_we_i |=> (gie_o == $past(gie_d_i)));
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i),
  .clr1_en_i(clr1_en_i), .clr1_bits_i(clr1_bits_i),
  .wr0_en_i(wr0_en_i), .wr0_bits_i(wr0_bits_i),
  .mask_we_i(mask_we_i), .mask_d_i(mask_d_i),
  .gie_we_i(gie_we_i), .gie_d_i(gie_d_i),
  .flag_o(flag_o), .mask_o(mask_o), .gie_o(gie_o), .irq_o(irq_o)
);

// File: tb/tmr_irq_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_irq_ctrl_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] evt_i, clr1_bits_i, wr0_bits_i, mask_d_i;
  logic         clr1_en_i, wr0_en_i, mask_we_i, gie_we_i, gie_d_i;
  logic [N-1:0] flag_o, mask_o;
  logic         gie_o, irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  // Bench model state
  logic [N-1:0] m_flag, m_mask;
  logic         m_gie, m_pq, m_irq;

  always #2.5 clk = ~clk;

  tmr_irq_ctrl #(.N_SRC(N)) u_tmr_irq_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .clr1_en_i(clr1_en_i), .clr1_bits_i(clr1_bits_i),
    .wr0_en_i(wr0_en_i), .wr0_bits_i(wr0_bits_i),
    .mask_we_i(mask_we_i), .mask_d_i(mask_d_i),
    .gie_we_i(gie_we_i), .gie_d_i(gie_d_i),
    .flag_o(flag_o), .mask_o(mask_o), .gie_o(gie_o), .irq_o(irq_o)
  );

  function automatic logic [N-1:0] next_flags(
      logic [N-1:0] f, logic [N-1:0] e, logic c1, logic [N-1:0] c1b,
      logic w0, logic [N-1:0] w0b);
    logic [N-1:0] kill;
    kill = ({N{c1}} & c1b) | ({N{w0}} & ~w0b);
    return e | (f & ~kill);
  endfunction

  function automatic logic masked_pend(logic [N-1:0] f, logic [N-1:0] m, logic g);
    return g & (|(f & m));
  endfunction

  task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    evt_i = '0; clr1_en_i = 0; clr1_bits_i = '0; wr0_en_i = 0; wr0_bits_i = '1;
    mask_we_i = 0; mask_d_i = '0; gie_we_i = 0; gie_d_i = 0;
  endtask

  // Apply current inputs for one edge, advance model, compare outputs
  task automatic step(string tag);
    logic p;
    @(posedge clk);
    p      = masked_pend(m_flag, m_mask, m_gie);
    m_irq  = p & ~m_pq;
    m_pq   = p;
    m_flag = next_flags(m_flag, evt_i, clr1_en_i, clr1_bits_i, wr0_en_i, wr0_bits_i);
    if (mask_we_i) m_mask = mask_d_i;
    if (gie_we_i)  m_gie  = gie_d_i;
    #1;
    check(tag, "flag", flag_o, m_flag);
    check(tag, "mask", mask_o, m_mask);
    check(tag, "gie",  {3'b0, gie_o}, {3'b0, m_gie});
    check(tag, "irq",  {3'b0, irq_o}, {3'b0, m_irq});
    @(negedge clk);
    idle_inputs();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    rst = 1'b1;
    m_flag = '0; m_mask = '0; m_gie = 0; m_pq = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9: state after reset
    check("R9", "flag", flag_o, '0);
    check("R9", "mask", mask_o, '0);
    check("R9", "irq",  {3'b0, irq_o}, '0);

    // R2/R1: channel 1 event (bit 2) with nothing enabled
    evt_i = 4'b0100; step("R2");
    step("R2");  // sticky, no pulse
    // R3: mask in but global enable off
    mask_we_i = 1; mask_d_i = 4'b0100; step("R3");
    step("R3");
    // R6: global enable on over a waiting flag
    gie_we_i = 1; gie_d_i = 1; step("R6");
    step("R6");  // pulse lands here
    step("R4");  // pulse gone
    // R5: further masked event while pending, no new pulse
    mask_we_i = 1; mask_d_i = 4'b0101; step("R10");
    evt_i = 4'b0001; step("R5");
    step("R5"); step("R5");
    // R7: write-one-to-clear bit 2, write-zero clears bit 0
    clr1_en_i = 1; clr1_bits_i = 4'b0100; step("R7");
    wr0_en_i = 1; wr0_bits_i = 4'b1110; step("R7");
    step("R7");
    // R5: after clearing, new terminal-count event pulses
    evt_i = 4'b0001; step("R5");
    step("R5"); step("R4");
    // R8: event colliding with clear on same bit
    evt_i = 4'b0001; clr1_en_i = 1; clr1_bits_i = 4'b0001; step("R8");
    evt_i = 4'b1000; wr0_en_i = 1; wr0_bits_i = 4'b0111; step("R8");
    // R6: mask enabled over waiting channel 2 flag after clearing rest
    wr0_en_i = 1; wr0_bits_i = 4'b1000; step("R7");
    step("R7");
    mask_we_i = 1; mask_d_i = 4'b1000; step("R6");
    step("R6"); step("R4");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      for (int b = 0; b < N; b++) evt_i[b] = ($urandom % 10) == 0;
      if (($urandom % 6) == 0) begin clr1_en_i = 1; clr1_bits_i = N'($urandom); end
      if (($urandom % 8) == 0) begin wr0_en_i = 1; wr0_bits_i = N'($urandom); end
      if (($urandom % 12) == 0) begin mask_we_i = 1; mask_d_i = N'($urandom); end
      if (($urandom % 20) == 0) begin gie_we_i = 1; gie_d_i = 1'($urandom); end
      step("R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule